// File: doc/BRIEF.md
# SPI Interrupt Status and Mask Unit

This unit gathers the interrupt sources of an SPI master into one status word, gates them with a mask, and drives a single interrupt line. Three sources are sticky events: receive overflow, mode fault and transmit underflow. Each is captured from a one-cycle pulse and held until software acknowledges it. The other four sources are live levels computed every cycle from the FIFO occupancy counts. Two of these levels compare the counts against thresholds that software can program. The other two flag a full FIFO.

Software changes the mask only through two strobe registers. Writing ones to the enable register sets mask bits, and writing ones to the disable register clears them. The mask itself is read-only, so a read-modify-write sequence is never needed. Writing back the status value just read acknowledges every pending sticky event. The FIFOs and the shift engine sit outside this unit, which sees only their counts and event pulses.

Top module: `spi_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0, both thresholds read 1, every sticky status bit is 0 and `irq` is 0.
- R2: A one-cycle pulse on `rx_ovf_evt`, `mode_fault_evt` or `tx_udf_evt` sets status bit 0, 1 or 6 respectively from the next clock edge. The bit stays set until it is cleared.
- R3: A write to the status register (offset 0x04) clears each sticky bit whose data bit is 1. An event pulse in the same cycle as the clear wins, and the bit stays set.
- R4: Status bit 2 is 1 while `tx_count` is below the transmit threshold. Status bit 4 is 1 while `rx_count` is at or above the receive threshold. Both bits follow the counts with no delay, and a status write has no effect on them.
- R5: Status bit 3 is 1 exactly when `tx_count` equals DEPTH. Status bit 5 is 1 exactly when `rx_count` equals DEPTH.
- R6: A write to the enable register (offset 0x08) sets the mask bits where the data is 1. A write to the disable register (offset 0x0C) clears the mask bits where the data is 1. Mask bits where the data is 0 keep their value.
- R7: The mask register (offset 0x10) is read-only, and a write to it leaves the mask unchanged. Reads of the enable and disable offsets, and of any unmapped offset, return 0.
- R8: `irq` is the OR of (status AND mask), registered, so it follows that value one clock edge later.
- R9: The transmit threshold (offset 0x18) and the receive threshold (offset 0x1C) are read/write registers. Each stores the low CNT_W bits of the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset for a read or a write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| rx_ovf_evt | input | 1 | Receive overflow pulse |
| mode_fault_evt | input | 1 | Mode fault pulse |
| tx_udf_evt | input | 1 | Transmit underflow pulse |
| irq | output | 1 | Interrupt request |

## Verification
Register reads are combinational, so the bench samples `reg_rdata` one time unit after it sets the address at a falling edge. The live level and full bits are checked in that same cycle, across every occupancy from 0 to DEPTH and several threshold values. Sticky bits, mask updates and threshold values are due at the first rising edge after the stimulus, so the bench reads them at the following falling edge. `irq` lags one edge further: the bench checks that it still holds its old value at the first falling edge after a mask or status change, and that it takes the new value at the next falling edge.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

  localparam int NBITS = 7;

  // status bit positions
  localparam int B_RXOVF   = 0;
  localparam int B_MODF    = 1;
  localparam int B_TXLOW   = 2;
  localparam int B_TXFULL  = 3;
  localparam int B_RXAVAIL = 4;
  localparam int B_RXFULL  = 5;
  localparam int B_TXUNDF  = 6;

  localparam logic [NBITS-1:0] STICKY_BITS = 7'b100_0011;

  // register byte offsets
  localparam logic [7:0] OFS_STATUS  = 8'h04;
  localparam logic [7:0] OFS_ENABLE  = 8'h08;
  localparam logic [7:0] OFS_DISABLE = 8'h0C;
  localparam logic [7:0] OFS_MASK    = 8'h10;
  localparam logic [7:0] OFS_TX_THR  = 8'h18;
  localparam logic [7:0] OFS_RX_THR  = 8'h1C;

  // live (level-type) status bits from occupancy and thresholds
  function automatic logic [NBITS-1:0] level_bits(
    input logic [31:0] txc,
    input logic [31:0] rxc,
    input logic [31:0] txt,
    input logic [31:0] rxt,
    input logic [31:0] depth
  );
    logic [NBITS-1:0] v;
    v = '0;
    v[B_TXLOW]   = (txc < txt);
    v[B_TXFULL]  = (txc == depth);
    v[B_RXAVAIL] = (rxc >= rxt);
    v[B_RXFULL]  = (rxc == depth);
    return v;
  endfunction

  // next value of a sticky vector: set has priority over clear
  function automatic logic [NBITS-1:0] sticky_next(
    input logic [NBITS-1:0] cur,
    input logic [NBITS-1:0] set,
    input logic [NBITS-1:0] clr
  );
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/spi_irq_levels.sv
module spi_irq_levels
  import spi_irq_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic [CNT_W-1:0] tx_thr_i,
  input  logic [CNT_W-1:0] rx_thr_i,
  output logic [NBITS-1:0] live_o
);

  localparam logic [31:0] DEPTH_V = 32'(DEPTH);

  always_comb begin
    live_o = level_bits(32'(tx_cnt_i), 32'(rx_cnt_i),
                        32'(tx_thr_i), 32'(rx_thr_i), DEPTH_V);
  end

endmodule

// File: rtl/spi_irq_sticky.sv
module spi_irq_sticky
  import spi_irq_pkg::*;
#(
  parameter logic [NBITS-1:0] KEEP = STICKY_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] set_i,
  input  logic [NBITS-1:0] clr_i,
  output logic [NBITS-1:0] q_o
);

  logic [NBITS-1:0] nxt;
  assign nxt = sticky_next(q_o, set_i, clr_i);

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    if (KEEP[i]) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o[i] <= 1'b0;
        else        q_o[i] <= nxt[i];
      end
    end else begin : g_tie
      assign q_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask
  import spi_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_stb_i,
  input  logic             clr_stb_i,
  input  logic [NBITS-1:0] bits_i,
  output logic [NBITS-1:0] mask_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_o <= '0;
    else if (set_stb_i) mask_o <= mask_o | bits_i;
    else if (clr_stb_i) mask_o <= mask_o & ~bits_i;
  end

endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic              rx_ovf_evt,
  input  logic              mode_fault_evt,
  input  logic              tx_udf_evt,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_ENABLE  = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_DISABLE = ADDR_W'(OFS_DISABLE);
  localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_TX_THR  = ADDR_W'(OFS_TX_THR);
  localparam logic [ADDR_W-1:0] A_RX_THR  = ADDR_W'(OFS_RX_THR);
  localparam logic [CNT_W-1:0]  THR_RESET = CNT_W'(1);

  // named internal events, also observed by the checker
  logic             wr_stat, wr_ena, wr_dis, wr_txt, wr_rxt;
  logic [NBITS-1:0] wbits;
  logic [NBITS-1:0] sticky_set, sticky_clr, sticky_vec;
  logic [NBITS-1:0] live_vec, status_vec, mask_vec;
  logic [CNT_W-1:0] tx_thr, rx_thr;
  logic             unused_wdata_hi;

  assign wr_stat = reg_wr && (reg_addr == A_STATUS);
  assign wr_ena  = reg_wr && (reg_addr == A_ENABLE);
  assign wr_dis  = reg_wr && (reg_addr == A_DISABLE);
  assign wr_txt  = reg_wr && (reg_addr == A_TX_THR);
  assign wr_rxt  = reg_wr && (reg_addr == A_RX_THR);
  assign wbits   = reg_wdata[NBITS-1:0];
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:CNT_W];

  always_comb begin
    sticky_set = '0;
    sticky_set[B_RXOVF]  = rx_ovf_evt;
    sticky_set[B_MODF]   = mode_fault_evt;
    sticky_set[B_TXUNDF] = tx_udf_evt;
  end
  assign sticky_clr = wr_stat ? (wbits & STICKY_BITS) : '0;

  spi_irq_sticky #(.KEEP(STICKY_BITS)) u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (sticky_set),
    .clr_i (sticky_clr),
    .q_o   (sticky_vec)
  );

  spi_irq_levels #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_levels (
    .tx_cnt_i (tx_count),
    .rx_cnt_i (rx_count),
    .tx_thr_i (tx_thr),
    .rx_thr_i (rx_thr),
    .live_o   (live_vec)
  );

  assign status_vec = sticky_vec | live_vec;

  spi_irq_mask u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_stb_i (wr_ena),
    .clr_stb_i (wr_dis),
    .bits_i    (wbits),
    .mask_o    (mask_vec)
  );

  // programmable thresholds
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_thr <= THR_RESET;
      rx_thr <= THR_RESET;
    end else begin
      if (wr_txt) tx_thr <= reg_wdata[CNT_W-1:0];
      if (wr_rxt) rx_thr <= reg_wdata[CNT_W-1:0];
    end
  end

  // registered interrupt line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(status_vec & mask_vec);
  end

  // read mux
  always_comb begin
    case (reg_addr)
      A_STATUS: reg_rdata = DATA_W'(status_vec);
      A_MASK:   reg_rdata = DATA_W'(mask_vec);
      A_TX_THR: reg_rdata = DATA_W'(tx_thr);
      A_RX_THR: reg_rdata = DATA_W'(rx_thr);
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/spi_irq_chk.sv
module spi_irq_chk
  import spi_irq_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_ovf_evt,
  input logic             mode_fault_evt,
  input logic             tx_udf_evt,
  input logic             wr_stat,
  input logic             wr_ena,
  input logic             wr_dis,
  input logic [NBITS-1:0] wbits,
  input logic [NBITS-1:0] status_vec,
  input logic [NBITS-1:0] mask_vec,
  input logic [CNT_W-1:0] tx_count,
  input logic [CNT_W-1:0] rx_count,
  input logic             irq
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  assert_ovf_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf_evt |=> status_vec[B_RXOVF]);

  assert_udf_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_udf_evt |=> status_vec[B_TXUNDF]);

  assert_ovf_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wbits[B_RXOVF] && !rx_ovf_evt) |=> !status_vec[B_RXOVF]);

  assert_full_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == FULL_CNT) |-> (status_vec[B_TXFULL] && !status_vec[B_TXLOW]
                                || status_vec[B_TXFULL]));

  assert_rx_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == FULL_CNT) |-> status_vec[B_RXFULL]);

  assert_mask_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ena |=> ((mask_vec & $past(wbits)) == $past(wbits)));

  assert_mask_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dis |=> ((mask_vec & $past(wbits)) == '0));

  assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ena || wr_dis) |=> $stable(mask_vec));

  assert_irq_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(status_vec & mask_vec))));

  assert_modf_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fault_evt |=> status_vec[B_MODF]);

endmodule

bind spi_irq_ctrl spi_irq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rx_ovf_evt     (rx_ovf_evt),
  .mode_fault_evt (mode_fault_evt),
  .tx_udf_evt     (tx_udf_evt),
  .wr_stat        (wr_stat),
  .wr_ena         (wr_ena),
  .wr_dis         (wr_dis),
  .wbits          (wbits),
  .status_vec     (status_vec),
  .mask_vec       (mask_vec),
  .tx_count       (tx_count),
  .rx_count       (rx_count),
  .irq            (irq)
);

// File: tb/tb_spi_irq_ctrl.sv
module tb_spi_irq_ctrl;

  localparam int DEPTH  = 128;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [7:0] A_STAT = 8'h04, A_ENA = 8'h08, A_DIS = 8'h0C,
                         A_MASK = 8'h10, A_TXT = 8'h18, A_RXT = 8'h1C;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic [CNT_W-1:0]  tx_count = '0;
  logic [CNT_W-1:0]  rx_count = '0;
  logic              rx_ovf_evt = 1'b0;
  logic              mode_fault_evt = 1'b0;
  logic              tx_udf_evt = 1'b0;
  logic              irq;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;
  logic [31:0] rv;

  always #2 clk = ~clk;  // 250 MHz

  spi_irq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_count(tx_count),
    .rx_count(rx_count), .rx_ovf_evt(rx_ovf_evt), .mode_fault_evt(mode_fault_evt),
    .tx_udf_evt(tx_udf_evt), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  function automatic logic [31:0] exp_live(input int c, input int tthr, input int rthr);
    logic [31:0] e;
    e = 0;
    if (c < tthr)   e = e | 32'h04;
    if (c == DEPTH) e = e | 32'h08 | 32'h20;
    if (c >= rthr)  e = e | 32'h10;
    return e;
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_STAT, rv); check("R1 status", rv, 32'h04);
    rd(A_MASK, rv); check("R1 mask", rv, 32'h0);
    rd(A_TXT, rv);  check("R1 tx thr", rv, 32'h1);
    rd(A_RXT, rv);  check("R1 rx thr", rv, 32'h1);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2 sticky overflow
    @(negedge clk); rx_ovf_evt = 1'b1;
    @(negedge clk); rx_ovf_evt = 1'b0;
    rd(A_STAT, rv); check("R2 ovf set", rv, 32'h05);
    repeat (3) @(negedge clk);
    rd(A_STAT, rv); check("R2 ovf held", rv, 32'h05);
    check("R8 irq masked", {31'b0, irq}, 32'h0);

    // R8 irq one edge after mask change
    wr(A_ENA, 32'h01);
    check("R8 irq lag on", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R8 irq on", {31'b0, irq}, 32'h1);
    rd(A_MASK, rv); check("R6 enable", rv, 32'h01);

    // R3 clear, irq drops one edge later
    wr(A_STAT, 32'h01);
    check("R8 irq lag off", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R8 irq off", {31'b0, irq}, 32'h0);
    rd(A_STAT, rv); check("R3 cleared", rv, 32'h04);

    // R3 set wins over same-cycle clear
    @(negedge clk);
    rx_ovf_evt = 1'b1; reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h01;
    @(negedge clk);
    rx_ovf_evt = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    rd(A_STAT, rv); check("R3 set wins", rv, 32'h05);

    // R2 mode fault and underflow, R3 partial clear, R4 live bits untouched
    @(negedge clk); mode_fault_evt = 1'b1; tx_udf_evt = 1'b1;
    @(negedge clk); mode_fault_evt = 1'b0; tx_udf_evt = 1'b0;
    rd(A_STAT, rv); check("R2 modf udf", rv, 32'h47);
    wr(A_STAT, 32'h40);
    rd(A_STAT, rv); check("R3 partial", rv, 32'h07);
    wr(A_STAT, 32'h7F);
    rd(A_STAT, rv); check("R4 live kept", rv, 32'h04);

    // R6 and R7 mask strobes
    wr(A_ENA, 32'h7F);  rd(A_MASK, rv); check("R6 all set", rv, 32'h7F);
    wr(A_DIS, 32'h05);  rd(A_MASK, rv); check("R6 clear some", rv, 32'h7A);
    wr(A_DIS, 32'h00);  rd(A_MASK, rv); check("R6 zero dis", rv, 32'h7A);
    wr(A_ENA, 32'h00);  rd(A_MASK, rv); check("R6 zero ena", rv, 32'h7A);
    wr(A_MASK, 32'h00); rd(A_MASK, rv); check("R7 mask ro", rv, 32'h7A);
    rd(A_ENA, rv); check("R7 ena reads 0", rv, 32'h0);
    rd(A_DIS, rv); check("R7 dis reads 0", rv, 32'h0);
    rd(8'h20, rv); check("R7 unmapped", rv, 32'h0);
    wr(A_DIS, 32'h7F);  rd(A_MASK, rv); check("R6 all clear", rv, 32'h0);

    // R8 live level drives irq
    wr(A_ENA, 32'h10);
    repeat (2) @(negedge clk);
    check("R8 rx empty no irq", {31'b0, irq}, 32'h0);
    rx_count = 1;
    #1; check("R8 live lag", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R8 live irq", {31'b0, irq}, 32'h1);
    rx_count = 0;
    wr(A_DIS, 32'h7F);

    // R9 thresholds
    wr(A_TXT, 32'h40); rd(A_TXT, rv); check("R9 tx thr", rv, 32'h40);
    wr(A_RXT, 32'h1FF); rd(A_RXT, rv); check("R9 rx thr trunc", rv, 32'hFF);

    // R4 R5 sweep of occupancy against thresholds
    for (int t = 0; t < 5; t++) begin
      int thr;
      case (t)
        0: thr = 1;
        1: thr = 3;
        2: thr = 64;
        3: thr = 127;
        default: thr = 128;
      endcase
      wr(A_TXT, 32'(thr));
      wr(A_RXT, 32'(thr));
      for (int c = 0; c <= DEPTH; c++) begin
        tx_count = CNT_W'(c);
        rx_count = CNT_W'(c);
        rd(A_STAT, rv);
        check($sformatf("R4 R5 thr %0d cnt %0d", thr, c), rv, exp_live(c, thr, thr));
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule